// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a memory-mapped watchdog. It has one clock and a plain register bus with address, write enable, write data and combinational read data. Software controls it only by writing 16-bit magic values to a write-only key register. One value starts the watchdog. Another reloads it. Two more open and close write access to the configuration registers. Once started, the watchdog cannot be stopped by any write. Only a system reset clears it.

A clock-enable input `tick_en` marks the slow timebase. A prescaler divides it by four times a power of two. Each prescaler period decrements a down-counter. When a prescaler period ends with the counter already at zero, the block raises a one-cycle reset request, reloads the counter and keeps counting.

New divide and reload values are applied after a fixed number of ticks, and a status register shows which updates are still pending. A window register can make reloads legal only once the counter has fallen to or below the window value.

Top module: `kwdt_top`

## Requirements
- R1: After reset the registers read as follows: divide code 0, reload 0xFFF, window 0xFFF, status 0. A read of the key offset returns 0, and `rst_req` is low.
- R2: The byte offsets are: key 0x00, divide code 0x04, reload value 0x08, status 0x0C, window 0x10. The reload and window fields are bits [11:0]. The divide code is bits [3:0] on write.
- R3: Writing key 0xCCCC starts the watchdog and loads the counter with the applied reload value. With `tick_en` high every cycle, `rst_req` is registered at the clock edge (reload+1)·4·2^code cycles after the start edge.
- R4: Once started, the watchdog keeps running through any key value, including 0x0000 and unknown values, until system reset.
- R5: Writing key 0xAAAA reloads the counter and restarts the prescaler phase. The next expiry is then (reload+1)·4·2^code ticks after that write edge.
- R6: Key 0x5555 opens writes to the divide, reload and window registers, and key 0x0000 closes them. Writes made while closed are ignored. Unknown key values change nothing.
- R7: A divide code c selects division by 4·2^c. A written code above log2(MAX_DIV)−2 is stored as that maximum (6 for the default MAX_DIV of 256).
- R8: Status bit 0 (divide busy) and bit 1 (reload busy) are set by an accepted write. Each clears after BUSY_TICKS edges with `tick_en` high, and the new value takes effect at that point. While `tick_en` is low the flags hold.
- R9: After an expiry the counter reloads and counts again, so without reloads `rst_req` pulses once every timeout period.
- R10: A 0xAAAA write made while running, with the counter above the window value, registers `rst_req` at that write edge. A window of 0xFFF accepts every reload.
- R11: `rst_req` is never high while the watchdog is not running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| tick_en | input | 1 | Timebase enable, one per input tick |
| bus_addr | input | 5 | Byte offset of the accessed register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The timeout is measured in clock edges for two divide and reload pairs (4 with 2, and 8 with 3). This separates a wrong prescaler ratio from an off-by-one in the counter's terminal count.

Free-running expiries show the automatic reload. A train of periodic reloads shows that servicing prevents any request.

Key writes of 0x0000 and of an unknown value during running show that the block cannot be stopped. Writes with the lock closed show that configuration is protected.

Early and late reloads against a window of 2 show which reloads are accepted. Holding `tick_en` low during a pending update shows that the busy flags count ticks and not clocks.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
    localparam int BUS_AW = 5;
    localparam int BUS_DW = 16;

    localparam logic [BUS_AW-1:0] OFF_KEY = 5'h00;
    localparam logic [BUS_AW-1:0] OFF_DIV = 5'h04;
    localparam logic [BUS_AW-1:0] OFF_RLD = 5'h08;
    localparam logic [BUS_AW-1:0] OFF_STS = 5'h0C;
    localparam logic [BUS_AW-1:0] OFF_WIN = 5'h10;

    localparam logic [BUS_DW-1:0] KEY_KICK = 16'hAAAA;
    localparam logic [BUS_DW-1:0] KEY_RUN  = 16'hCCCC;
    localparam logic [BUS_DW-1:0] KEY_OPEN = 16'h5555;
    localparam logic [BUS_DW-1:0] KEY_SHUT = 16'h0000;
endpackage

// File: rtl/kwdt_shadow.sv
// One configuration register with a delayed apply and a busy flag.
module kwdt_shadow #(
    parameter int          W          = 12,
    parameter logic [W-1:0] RST_VAL   = '0,
    parameter int          BUSY_TICKS = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr,
    input  logic [W-1:0] wval,
    output logic [W-1:0] shadow,
    output logic [W-1:0] active,
    output logic         busy
);
    localparam int BW = $clog2(BUSY_TICKS + 1);

    typedef struct packed {
        logic [W-1:0]  shadow;
        logic [W-1:0]  active;
        logic [BW-1:0] busy_cnt;
    } shd_t;

    shd_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (wr) begin
            sh_d.shadow   = wval;
            sh_d.busy_cnt = BW'(BUSY_TICKS);
        end else if (tick && sh_q.busy_cnt != '0) begin
            sh_d.busy_cnt = sh_q.busy_cnt - 1'b1;
            if (sh_q.busy_cnt == BW'(1)) begin
                sh_d.active = sh_q.shadow;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q.shadow   <= RST_VAL;
            sh_q.active   <= RST_VAL;
            sh_q.busy_cnt <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign shadow = sh_q.shadow;
    assign active = sh_q.active;
    assign busy   = (sh_q.busy_cnt != '0);
endmodule

// File: rtl/kwdt_gate.sv
// Key decoding, run and lock state, window register.
module kwdt_gate import kwdt_pkg::*; #(
    parameter int CNT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic              running,
    output logic              unlocked,
    output logic              load,
    output logic              wr_div,
    output logic              wr_rld,
    output logic [CNT_W-1:0]  win_val
);
    typedef struct packed {
        logic             run;
        logic             open;
        logic [CNT_W-1:0] win;
    } gate_t;

    gate_t g_d, g_q;
    logic  key_wr;

    always_comb begin
        key_wr = bus_we && (bus_addr == OFF_KEY);
        load   = key_wr && (bus_wdata == KEY_KICK || bus_wdata == KEY_RUN);
        wr_div = bus_we && g_q.open && (bus_addr == OFF_DIV);
        wr_rld = bus_we && g_q.open && (bus_addr == OFF_RLD);

        g_d = g_q;
        if (key_wr) begin
            case (bus_wdata)
                KEY_RUN:  g_d.run  = 1'b1;
                KEY_OPEN: g_d.open = 1'b1;
                KEY_SHUT: g_d.open = 1'b0;
                default:  g_d = g_q;
            endcase
        end
        if (bus_we && g_q.open && bus_addr == OFF_WIN) begin
            g_d.win = bus_wdata[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q.run  <= 1'b0;
            g_q.open <= 1'b0;
            g_q.win  <= '1;
        end else begin
            g_q <= g_d;
        end
    end

    assign running  = g_q.run;
    assign unlocked = g_q.open;
    assign win_val  = g_q.win;
endmodule

// File: rtl/kwdt_core.sv
// Prescaler, down-counter, window check and reset request.
module kwdt_core #(
    parameter int MAX_DIV = 256,
    parameter int CNT_W   = 12,
    parameter int PCW     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             running,
    input  logic             load,
    input  logic [PCW-1:0]   div_code,
    input  logic [CNT_W-1:0] rld_val,
    input  logic [CNT_W-1:0] win_val,
    output logic             rst_req
);
    localparam int PRE_W = $clog2(MAX_DIV);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
        logic             req;
    } core_t;

    core_t c_d, c_q;
    logic [PRE_W:0]   div_full;
    logic [PRE_W-1:0] div_m1;

    always_comb begin
        div_full = (PRE_W + 1)'(4) << div_code;
        div_m1   = PRE_W'(div_full - 1'b1);

        c_d     = c_q;
        c_d.req = 1'b0;
        if (load) begin
            c_d.pre = '0;
            c_d.cnt = rld_val;
            if (running && c_q.cnt > win_val) begin
                c_d.req = 1'b1;
            end
        end else if (running && tick) begin
            if (c_q.pre >= div_m1) begin
                c_d.pre = '0;
                if (c_q.cnt == '0) begin
                    c_d.cnt = rld_val;
                    c_d.req = 1'b1;
                end else begin
                    c_d.cnt = c_q.cnt - 1'b1;
                end
            end else begin
                c_d.pre = c_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.pre <= '0;
            c_q.cnt <= '1;
            c_q.req <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign rst_req = c_q.req;
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top import kwdt_pkg::*; #(
    parameter int MAX_DIV    = 256,
    parameter int CNT_W      = 12,
    parameter int BUSY_TICKS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic              rst_req
);
    localparam int MAXCODE = $clog2(MAX_DIV) - 2;
    localparam int PCW     = (MAXCODE < 1) ? 1 : $clog2(MAXCODE + 1);

    logic             running, unlocked, load, wr_div, wr_rld;
    logic [CNT_W-1:0] win_val, rld_shadow, rld_active;
    logic [PCW-1:0]   div_wcode, div_shadow, div_active;
    logic             div_busy, rld_busy;
    logic [1:0]       status_bits;

    kwdt_gate #(.CNT_W(CNT_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .running(running), .unlocked(unlocked),
        .load(load), .wr_div(wr_div), .wr_rld(wr_rld), .win_val(win_val)
    );

    // Saturate an out-of-range divide code to the largest legal one.
    always_comb begin
        if (bus_wdata[3:0] > 4'(MAXCODE)) div_wcode = PCW'(MAXCODE);
        else                              div_wcode = PCW'(bus_wdata[3:0]);
    end

    kwdt_shadow #(.W(PCW), .RST_VAL('0), .BUSY_TICKS(BUSY_TICKS)) u_div (
        .clk(clk), .rst_n(rst_n), .tick(tick_en), .wr(wr_div),
        .wval(div_wcode), .shadow(div_shadow), .active(div_active),
        .busy(div_busy)
    );

    kwdt_shadow #(.W(CNT_W), .RST_VAL('1), .BUSY_TICKS(BUSY_TICKS)) u_rld (
        .clk(clk), .rst_n(rst_n), .tick(tick_en), .wr(wr_rld),
        .wval(bus_wdata[CNT_W-1:0]), .shadow(rld_shadow),
        .active(rld_active), .busy(rld_busy)
    );

    kwdt_core #(.MAX_DIV(MAX_DIV), .CNT_W(CNT_W), .PCW(PCW)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick_en), .running(running),
        .load(load), .div_code(div_active), .rld_val(rld_active),
        .win_val(win_val), .rst_req(rst_req)
    );

    assign status_bits = {rld_busy, div_busy};

    always_comb begin
        case (bus_addr)
            OFF_DIV: bus_rdata = BUS_DW'(div_shadow);
            OFF_RLD: bus_rdata = BUS_DW'(rld_shadow);
            OFF_STS: bus_rdata = BUS_DW'(status_bits);
            OFF_WIN: bus_rdata = BUS_DW'(win_val);
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk import kwdt_pkg::*; #(
    parameter int CNT_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              running,
    input logic              unlocked,
    input logic              bus_we,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [CNT_W-1:0]  rld_shadow,
    input logic [1:0]        status_bits,
    input logic              rst_req
);
    assert_run_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running);

    assert_locked_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFF_RLD && !unlocked) |=> $stable(rld_shadow));

    assert_busy_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_bits[1]) |-> $past(bus_we && bus_addr == OFF_RLD && unlocked));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !rst_req);
endmodule

bind kwdt_top kwdt_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .running(running), .unlocked(unlocked),
    .bus_we(bus_we), .bus_addr(bus_addr), .rld_shadow(rld_shadow),
    .status_bits(status_bits), .rst_req(rst_req)
);

// File: tb/sim_kwdt_top.sv
`timescale 1ns/1ps
module sim_kwdt_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        rst_req;

    int n_checks = 0;
    int n_fail = 0;
    int edge_cnt = 0;
    int last_edge = 0;
    bit ignore_req = 1'b1;
    int exp_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) edge_cnt <= edge_cnt + 1;

    kwdt_top u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rst_req(rst_req)
    );

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [4:0] a, logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        #1 last_edge = edge_cnt;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(logic [4:0] a, output int v);
        @(negedge clk);
        bus_addr = a;
        #1 v = int'(bus_rdata);
    endtask

    task automatic kick(int period);
        bus_write(5'h00, 16'hAAAA);
        exp_q.delete();
        exp_q.push_back(last_edge + period);
        exp_q.push_back(last_edge + 2 * period);
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic finish_up;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Monitor: each observed request must match the next expected edge.
    always @(negedge clk) begin
        if (rst_n && rst_req && !ignore_req) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected rst_req at edge", edge_cnt, -1);
            end else begin
                check("R3/R5/R9/R10 rst_req edge", edge_cnt, exp_q.pop_front());
            end
        end
    end

    initial begin
        #400000;
        check("watchdog expired", 1, 0);
        finish_up();
    end

    initial begin
        int v;
        wait_cyc(5);
        @(negedge clk) rst_n = 1'b1;

        // R1 / R2 reset values by offset
        bus_read(5'h04, v); check("R1 divide code", v, 0);
        bus_read(5'h08, v); check("R1 reload", v, 12'hFFF);
        bus_read(5'h10, v); check("R1 window", v, 12'hFFF);
        bus_read(5'h0C, v); check("R1 status", v, 0);
        bus_read(5'h00, v); check("R2 key reads zero", v, 0);
        check("R1 rst_req low", int'(rst_req), 0);

        // R6 locked writes and unknown key ignored
        bus_write(5'h08, 16'h0005);
        bus_read(5'h08, v); check("R6 locked reload write ignored", v, 12'hFFF);
        bus_write(5'h00, 16'h1234);
        bus_write(5'h08, 16'h0005);
        bus_read(5'h08, v); check("R6 unknown key keeps lock", v, 12'hFFF);

        // R8 busy flags count ticks
        bus_write(5'h00, 16'h5555);
        @(negedge clk) tick_en = 1'b0;
        bus_write(5'h08, 16'h0002);
        wait_cyc(4);
        bus_read(5'h0C, v); check("R8 reload busy held with tick low", v, 2);
        @(negedge clk) tick_en = 1'b1;
        wait_cyc(2);
        @(negedge clk); #1 check("R8 busy after two ticks", int'(bus_rdata), 2);
        wait_cyc(1);
        @(negedge clk); #1 check("R8 busy clear after three ticks", int'(bus_rdata), 0);
        bus_read(5'h08, v); check("R6 open reload write", v, 2);

        // R7 saturation of the divide code
        bus_write(5'h04, 16'h0007);
        bus_read(5'h04, v); check("R7 code saturates to 6", v, 6);
        bus_read(5'h0C, v); check("R8 divide busy bit0", v, 1);
        bus_write(5'h04, 16'h0000);
        wait_cyc(5);

        // R6 close and verify
        bus_write(5'h00, 16'h0000);
        bus_write(5'h08, 16'h0009);
        bus_read(5'h08, v); check("R6 closed reload write ignored", v, 2);

        // R3 start, R9 free-running repeat (div 4, reload 2 -> 12)
        bus_write(5'h00, 16'hCCCC);
        exp_q.delete();
        exp_q.push_back(last_edge + 12);
        exp_q.push_back(last_edge + 24);
        ignore_req = 1'b0;
        wait_cyc(26);
        check("R3/R9 both expiries seen", exp_q.size(), 0);

        // R4 no key stops it
        ignore_req = 1'b1;
        wait_cyc(1);
        kick(12);
        ignore_req = 1'b0;
        bus_write(5'h00, 16'h0000);
        bus_write(5'h00, 16'h1234);
        wait_cyc(24);
        check("R4 still expiring after stop attempts", exp_q.size(), 0);

        // R5 periodic kicks keep it quiet
        kick(12);
        for (int i = 0; i < 6; i++) begin
            wait_cyc(6);
            kick(12);
        end
        check("R5 no request while serviced", exp_q.size(), 2);
        wait_cyc(14);
        check("R5 expiry after last kick", exp_q.size(), 1);

        // R7 divide 8, reload 3 -> 32
        ignore_req = 1'b1;
        bus_write(5'h00, 16'h5555);
        bus_write(5'h04, 16'h0001);
        bus_write(5'h08, 16'h0003);
        wait_cyc(5);
        kick(32);
        ignore_req = 1'b0;
        wait_cyc(34);
        check("R7 divide-by-8 timeout seen", exp_q.size(), 1);

        // R10 window: reload 5, divide 4, window 2 -> period 24
        ignore_req = 1'b1;
        bus_write(5'h04, 16'h0000);
        bus_write(5'h08, 16'h0005);
        bus_write(5'h10, 16'h0002);
        wait_cyc(5);
        kick(24);
        wait_cyc(1);
        ignore_req = 1'b0;
        bus_write(5'h00, 16'hAAAA);
        exp_q.delete();
        exp_q.push_back(last_edge);
        exp_q.push_back(last_edge + 24);
        wait_cyc(14);
        check("R10 early reload flagged", exp_q.size(), 1);
        bus_write(5'h00, 16'hAAAA);
        exp_q.delete();
        exp_q.push_back(last_edge + 24);
        wait_cyc(3);
        check("R10 late reload accepted", exp_q.size(), 1);
        wait_cyc(23);
        check("R10 expiry after late reload", exp_q.size(), 0);

        ignore_req = 1'b1;
        finish_up();
    end
endmodule